// File: doc/BRIEF.md
# Microcoded Multicycle Control Unit

This block sequences a multicycle 32-bit datapath from a microcode store. Each cycle it reads one microinstruction at the current microaddress, turns its fields into datapath controls, and picks the next microaddress. The next address is one of four choices: the following word, the fetch word, a dispatch target or, for a trapping add, the overflow handler. The dispatch target comes from the opcode, and from the function field for register-format instructions. The datapath (PC, IR, MDR, ALUOut, a hold register, register file and memory) lives outside. It returns the instruction register contents, the ALU zero flag, the ALU signed-overflow flag and the current PC.

The unit covers unsigned add and subtract, OR-immediate, load word, store word, branch-if-equal, jump-and-link, a signed add that traps on overflow, a read of two exception registers, and a complex multiply on even/odd register pairs. The exception registers are a cause code and the PC of the faulting instruction, and they are held inside this block. The datapath's ALUOut register is loaded every cycle, and it loads the hold register from ALUOut on request.

Top module: `mcu_ctrl`

## Requirements
- R1: After reset `upc` is 0, and both exception registers read as 0 through `cop_rdata`.
- R2: At microaddress 0 (fetch) the unit asserts `mem_rd` and `ir_wr` with `iord`=0. It selects `alu_op`=0 (add; 1 sub, 2 or, 3 multiply) with `alu_src1`=0 (PC) and `alu_src2`=1 (constant 4). It asserts `pc_load` with `pc_src`=0 (ALU result), and the next microaddress is 1.
- R3: At microaddress 1 the unit adds PC (`alu_src1`=0) to the sign-extended, shifted immediate (`alu_src2`=3), loads no PC and writes no register. The next address then comes from the opcode in bits 31:26. Opcode 0 selects by the function field in bits 5:0: 0x21 or 0x23 go to 2, 0x20 to 13, 0x3A to 17. The other opcodes map as follows: 0x04 to 4, 0x0D to 5, 0x23 to 7, 0x2B to 10, 0x03 to 12, 0x10 to 16.
- R4: Unsigned add/subtract (addresses 2, 3) take `alu_op` from the function field (0x21 add, 0x23 subtract), with `ra_addr`=rs (bits 25:21) and `rb_addr`=rt (bits 20:16). They then write rd (bits 15:11) with `wr_src`=0 (ALUOut), even when `alu_ovf` is set, and return to 0.
- R5: The branch step (address 4) subtracts and asserts `pc_load` only when `alu_zero` is set, with `pc_src`=1 (ALUOut), then returns to 0.
- R6: OR-immediate uses `alu_src2`=4 (zero-extended immediate) and then writes rt from ALUOut. Load word forms the address with `alu_src2`=2 (sign-extended immediate), reads memory with `iord`=1, and writes rt with `wr_src`=1 (MDR). Store word forms the same address and then asserts `mem_wr` with `iord`=1 and no register write. `mem_rd` and `mem_wr` are never both high.
- R7: Jump-and-link (address 12) writes register 31 with `wr_src`=2 (PC, already advanced by 4), asserts `pc_load` with `pc_src`=2 (jump target), and returns to 0.
- R8: A trapping add (address 13) that sees `alu_ovf` goes to address 15. That step writes no register and asserts `pc_load` with `pc_src`=3 (exception vector). It also sets the cause register to 12 and the exception PC to `pc_cur` minus 4.
- R9: A trapping add without overflow goes to address 14, writes rd from ALUOut and returns to 0.
- R10: The exception-register read (address 16) writes rd with `wr_src`=3. `cop_rdata` gives the cause when rt is 13, the exception PC when rt is 14, and 0 for any other rt.
- R11: The complex multiply runs addresses 17 to 23 with `alu_src1` 1 (register A) or 2 (hold) and `alu_src2` 0 (register B) or 5 (ALUOut). In order, the seven steps are: multiply rs·rt; load hold and multiply (rs|1)·(rt|1); hold minus ALUOut; write rd and multiply rs·(rt|1); load hold and multiply (rs|1)·rt; hold plus ALUOut; write rd|1.
- R12: An opcode or function code not listed in R3 returns to address 0 straight after address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction register contents |
| alu_zero | input | 1 | ALU result is zero |
| alu_ovf | input | 1 | ALU signed overflow for the current operation |
| pc_cur | input | 32 | Current PC value |
| upc | output | 5 | Current microaddress |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| iord | output | 1 | Memory address from ALUOut (1) or PC (0) |
| ir_wr | output | 1 | Load instruction register |
| alu_op | output | 2 | 0 add, 1 sub, 2 or, 3 multiply |
| alu_src1 | output | 2 | 0 PC, 1 register A, 2 hold |
| alu_src2 | output | 3 | 0 register B, 1 four, 2 sext, 3 sext shifted, 4 zext, 5 ALUOut |
| ra_addr | output | 5 | Register-file read address A |
| rb_addr | output | 5 | Register-file read address B |
| reg_wr | output | 1 | Register-file write |
| wr_addr | output | 5 | Register-file write address |
| wr_src | output | 2 | 0 ALUOut, 1 MDR, 2 PC, 3 cop_rdata |
| hold_wr | output | 1 | Load hold register from ALUOut |
| pc_load | output | 1 | Load PC this cycle |
| pc_src | output | 2 | 0 ALU, 1 ALUOut, 2 jump target, 3 exception vector |
| cop_rdata | output | 32 | Selected exception register |

## Verification
The assertions check the fixed relations on every cycle. Fetch drives the same controls and always steps to decode. A trapping add branches to the handler exactly when overflow is seen, and to the commit step otherwise. The handler never writes a register, a write from the PC always targets register 31, and memory is never read and written together. Only the directed scenarios can show the rest: the full address trace and control word of each instruction, the pair addressing of the complex multiply, the non-trapping unsigned add, and the exception-register values read back after a trap.

// File: rtl/mcu_pkg.sv
// Shared types, microaddress map, microcode contents and dispatch map for the
// microcoded control unit. Assumes a 5-bit microaddress space.
package mcu_pkg;

    localparam int UA_W   = 5;
    localparam int REG_AW = 5;

    typedef logic [UA_W-1:0] uaddr_t;

    typedef enum logic [2:0] {AF_ADD, AF_SUB, AF_OR, AF_MUL, AF_FUNC} alu_fld_e;
    typedef enum logic [1:0] {S1_PC, S1_A, S1_HOLD} s1_e;
    typedef enum logic [2:0] {S2_B, S2_FOUR, S2_SEXT, S2_SHIFT, S2_ZEXT, S2_ALUOUT} s2_e;
    typedef enum logic [1:0] {M_NONE, M_RD_PC, M_RD_ALU, M_WR_ALU} mem_e;
    typedef enum logic [2:0] {RW_NONE, RW_RT_ALU, RW_RD_ALU, RW_RD1_ALU,
                              RW_RT_MDR, RW_R31_PC, RW_RD_COP} rw_e;
    typedef enum logic [2:0] {PW_NONE, PW_ALU, PW_COND, PW_JUMP, PW_VEC} pcw_e;
    typedef enum logic [1:0] {SQ_NEXT, SQ_FETCH, SQ_DISP, SQ_OVF} seq_e;

    typedef struct packed {
        alu_fld_e alu_f;
        s1_e      s1;
        s2_e      s2;
        logic     a_odd;
        logic     b_odd;
        mem_e     mem;
        rw_e      rw;
        logic     hold;
        logic     exc;
        pcw_e     pcw;
        seq_e     seq;
    } uinstr_t;

    localparam uaddr_t UA_FETCH  = 5'd0;
    localparam uaddr_t UA_DECODE = 5'd1;
    localparam uaddr_t UA_RTYPE  = 5'd2;
    localparam uaddr_t UA_RWB    = 5'd3;
    localparam uaddr_t UA_BEQ    = 5'd4;
    localparam uaddr_t UA_ORI    = 5'd5;
    localparam uaddr_t UA_ORIWB  = 5'd6;
    localparam uaddr_t UA_LW1    = 5'd7;
    localparam uaddr_t UA_LW2    = 5'd8;
    localparam uaddr_t UA_LW3    = 5'd9;
    localparam uaddr_t UA_SW1    = 5'd10;
    localparam uaddr_t UA_SW2    = 5'd11;
    localparam uaddr_t UA_JAL    = 5'd12;
    localparam uaddr_t UA_ADD1   = 5'd13;
    localparam uaddr_t UA_ADD2   = 5'd14;
    localparam uaddr_t UA_TRAP   = 5'd15;
    localparam uaddr_t UA_MFC0   = 5'd16;
    localparam uaddr_t UA_CM1    = 5'd17;
    localparam uaddr_t UA_CM2    = 5'd18;
    localparam uaddr_t UA_CM3    = 5'd19;
    localparam uaddr_t UA_CM4    = 5'd20;
    localparam uaddr_t UA_CM5    = 5'd21;
    localparam uaddr_t UA_CM6    = 5'd22;
    localparam uaddr_t UA_CM7    = 5'd23;

    localparam logic [5:0] OPC_RFMT = 6'h00;
    localparam logic [5:0] OPC_JAL  = 6'h03;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_COP  = 6'h10;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;
    localparam logic [5:0] FN_CMUL  = 6'h3A;

    // Pack one microinstruction from its fields.
    function automatic uinstr_t uw(alu_fld_e a, s1_e s1, s2_e s2, logic ao, logic bo,
                                   mem_e m, rw_e r, logic h, logic x, pcw_e p, seq_e s);
        uinstr_t w;
        w.alu_f = a;  w.s1 = s1;  w.s2 = s2;  w.a_odd = ao;  w.b_odd = bo;
        w.mem = m;    w.rw = r;   w.hold = h; w.exc = x;     w.pcw = p;  w.seq = s;
        return w;
    endfunction

    // Microcode contents; unused addresses return to fetch doing nothing.
    function automatic uinstr_t urom_word(uaddr_t ua);
        case (ua)
            UA_FETCH:  return uw(AF_ADD,  S1_PC,   S2_FOUR,   0, 0, M_RD_PC,  RW_NONE,    0, 0, PW_ALU,  SQ_NEXT);
            UA_DECODE: return uw(AF_ADD,  S1_PC,   S2_SHIFT,  0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_DISP);
            UA_RTYPE:  return uw(AF_FUNC, S1_A,    S2_B,      0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_NEXT);
            UA_RWB:    return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_RD_ALU,  0, 0, PW_NONE, SQ_FETCH);
            UA_BEQ:    return uw(AF_SUB,  S1_A,    S2_B,      0, 0, M_NONE,   RW_NONE,    0, 0, PW_COND, SQ_FETCH);
            UA_ORI:    return uw(AF_OR,   S1_A,    S2_ZEXT,   0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_NEXT);
            UA_ORIWB:  return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_RT_ALU,  0, 0, PW_NONE, SQ_FETCH);
            UA_LW1:    return uw(AF_ADD,  S1_A,    S2_SEXT,   0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_NEXT);
            UA_LW2:    return uw(AF_ADD,  S1_A,    S2_SEXT,   0, 0, M_RD_ALU, RW_NONE,    0, 0, PW_NONE, SQ_NEXT);
            UA_LW3:    return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_RT_MDR,  0, 0, PW_NONE, SQ_FETCH);
            UA_SW1:    return uw(AF_ADD,  S1_A,    S2_SEXT,   0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_NEXT);
            UA_SW2:    return uw(AF_ADD,  S1_A,    S2_SEXT,   0, 0, M_WR_ALU, RW_NONE,    0, 0, PW_NONE, SQ_FETCH);
            UA_JAL:    return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_R31_PC,  0, 0, PW_JUMP, SQ_FETCH);
            UA_ADD1:   return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_OVF);
            UA_ADD2:   return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_RD_ALU,  0, 0, PW_NONE, SQ_FETCH);
            UA_TRAP:   return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_NONE,    0, 1, PW_VEC,  SQ_FETCH);
            UA_MFC0:   return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_RD_COP,  0, 0, PW_NONE, SQ_FETCH);
            UA_CM1:    return uw(AF_MUL,  S1_A,    S2_B,      0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_NEXT);
            UA_CM2:    return uw(AF_MUL,  S1_A,    S2_B,      1, 1, M_NONE,   RW_NONE,    1, 0, PW_NONE, SQ_NEXT);
            UA_CM3:    return uw(AF_SUB,  S1_HOLD, S2_ALUOUT, 0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_NEXT);
            UA_CM4:    return uw(AF_MUL,  S1_A,    S2_B,      0, 1, M_NONE,   RW_RD_ALU,  0, 0, PW_NONE, SQ_NEXT);
            UA_CM5:    return uw(AF_MUL,  S1_A,    S2_B,      1, 0, M_NONE,   RW_NONE,    1, 0, PW_NONE, SQ_NEXT);
            UA_CM6:    return uw(AF_ADD,  S1_HOLD, S2_ALUOUT, 0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_NEXT);
            UA_CM7:    return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_RD1_ALU, 0, 0, PW_NONE, SQ_FETCH);
            default:   return uw(AF_ADD,  S1_A,    S2_B,      0, 0, M_NONE,   RW_NONE,    0, 0, PW_NONE, SQ_FETCH);
        endcase
    endfunction

    // Dispatch map from opcode and function code to the first flow word.
    function automatic uaddr_t dispatch(logic [5:0] opc, logic [5:0] fn);
        case (opc)
            OPC_RFMT: begin
                case (fn)
                    FN_ADDU, FN_SUBU: return UA_RTYPE;
                    FN_ADD:           return UA_ADD1;
                    FN_CMUL:          return UA_CM1;
                    default:          return UA_FETCH;
                endcase
            end
            OPC_BEQ: return UA_BEQ;
            OPC_ORI: return UA_ORI;
            OPC_LW:  return UA_LW1;
            OPC_SW:  return UA_SW1;
            OPC_JAL: return UA_JAL;
            OPC_COP: return UA_MFC0;
            default: return UA_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/mcu_urom.sv
// Microcode store: a combinational ROM of 2**UA_W words, filled from the
// package contents. Assumes the address is always within the store.
module mcu_urom
    import mcu_pkg::*;
#(
    parameter int DEPTH = 2 ** UA_W
) (
    input  uaddr_t  addr,
    output uinstr_t word
);
    uinstr_t rom [DEPTH];

    // Fill each ROM entry from the microcode contents.
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = urom_word(uaddr_t'(i));
    end

    // Read the addressed word.
    assign word = rom[addr];
endmodule

// File: rtl/mcu_useq.sv
// Microsequencer: holds the microaddress and selects the next one as the
// following word, fetch, a dispatch target, or the overflow handler.
// Assumes the overflow flag is valid in the cycle of the trapping add.
module mcu_useq
    import mcu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_e       seq,
    input  logic [5:0] opc,
    input  logic [5:0] fn,
    input  logic       ovf,
    output uaddr_t     upc
);
    uaddr_t upc_nxt;

    // Next-address choice from the sequence field.
    always_comb begin
        case (seq)
            SQ_NEXT:  upc_nxt = upc + uaddr_t'(1);
            SQ_FETCH: upc_nxt = UA_FETCH;
            SQ_DISP:  upc_nxt = dispatch(opc, fn);
            SQ_OVF:   upc_nxt = ovf ? UA_TRAP : upc + uaddr_t'(1);
            default:  upc_nxt = UA_FETCH;
        endcase
    end

    // Microaddress register with synchronous reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= UA_FETCH;
        else        upc <= upc_nxt;
    end
endmodule

// File: rtl/mcu_fdec.sv
// Field decoders: turn a microinstruction plus instruction fields into the
// datapath controls. The single PC-write field yields both the load enable
// (gated by the zero flag for branches) and the PC source select.
module mcu_fdec
    import mcu_pkg::*;
(
    input  uinstr_t           u,
    input  logic [5:0]        fn,
    input  logic [REG_AW-1:0] rs,
    input  logic [REG_AW-1:0] rt,
    input  logic [REG_AW-1:0] rd,
    input  logic              zero,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              iord,
    output logic              ir_wr,
    output logic [1:0]        alu_op,
    output logic [1:0]        alu_src1,
    output logic [2:0]        alu_src2,
    output logic [REG_AW-1:0] ra_addr,
    output logic [REG_AW-1:0] rb_addr,
    output logic              reg_wr,
    output logic [REG_AW-1:0] wr_addr,
    output logic [1:0]        wr_src,
    output logic              hold_wr,
    output logic              pc_load,
    output logic [1:0]        pc_src
);
    // ALU operation, with the function code deciding for register format.
    always_comb begin
        case (u.alu_f)
            AF_ADD:  alu_op = 2'd0;
            AF_SUB:  alu_op = 2'd1;
            AF_OR:   alu_op = 2'd2;
            AF_MUL:  alu_op = 2'd3;
            AF_FUNC: alu_op = (fn == FN_SUBU) ? 2'd1 : 2'd0;
            default: alu_op = 2'd0;
        endcase
    end

    assign alu_src1 = 2'(u.s1);
    assign alu_src2 = 3'(u.s2);
    assign hold_wr  = u.hold;
    assign ra_addr  = rs | REG_AW'(u.a_odd);
    assign rb_addr  = rt | REG_AW'(u.b_odd);

    // Memory field decode.
    always_comb begin
        mem_rd = 1'b0; mem_wr = 1'b0; iord = 1'b0; ir_wr = 1'b0;
        case (u.mem)
            M_RD_PC:  begin mem_rd = 1'b1; ir_wr = 1'b1; end
            M_RD_ALU: begin mem_rd = 1'b1; iord  = 1'b1; end
            M_WR_ALU: begin mem_wr = 1'b1; iord  = 1'b1; end
            default:  ;
        endcase
    end

    // Register-write field decode: destination and data source together.
    always_comb begin
        reg_wr = 1'b1; wr_addr = rd; wr_src = 2'd0;
        case (u.rw)
            RW_RT_ALU:  wr_addr = rt;
            RW_RD_ALU:  wr_addr = rd;
            RW_RD1_ALU: wr_addr = rd | REG_AW'(1);
            RW_RT_MDR:  begin wr_addr = rt; wr_src = 2'd1; end
            RW_R31_PC:  begin wr_addr = '1; wr_src = 2'd2; end
            RW_RD_COP:  wr_src = 2'd3;
            default:    reg_wr = 1'b0;
        endcase
    end

    // PC-write field decode into load enable and source select.
    always_comb begin
        pc_load = 1'b0; pc_src = 2'd0;
        case (u.pcw)
            PW_ALU:  pc_load = 1'b1;
            PW_COND: begin pc_load = zero; pc_src = 2'd1; end
            PW_JUMP: begin pc_load = 1'b1; pc_src = 2'd2; end
            PW_VEC:  begin pc_load = 1'b1; pc_src = 2'd3; end
            default: ;
        endcase
    end
endmodule

// File: rtl/mcu_cp0.sv
// Exception registers: cause and faulting PC, written together on a trap,
// read back by register selector. Assumes the PC already points one
// instruction past the faulting one when the trap step runs.
module mcu_cp0 #(
    parameter int DATA_W     = 32,
    parameter int CAUSE_CODE = 12,
    parameter int SEL_CAUSE  = 13,
    parameter int SEL_EPC    = 14,
    parameter int INSTR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap,
    input  logic [DATA_W-1:0] pc_cur,
    input  logic [4:0]        sel,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] epc_q;

    // Capture cause and faulting PC on a trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (trap) begin
            cause_q <= DATA_W'(CAUSE_CODE);
            epc_q   <= pc_cur - DATA_W'(INSTR_STEP);
        end
    end

    // Read-back selection.
    always_comb begin
        if (sel == 5'(SEL_CAUSE))    rdata = cause_q;
        else if (sel == 5'(SEL_EPC)) rdata = epc_q;
        else                         rdata = '0;
    end
endmodule

// File: rtl/mcu_ctrl.sv
// Top of the microcoded control unit: microsequencer, microcode store,
// field decoders and exception registers. The datapath is external and
// supplies the instruction register, ALU flags and the current PC.
module mcu_ctrl
    import mcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr,
    input  logic              alu_zero,
    input  logic              alu_ovf,
    input  logic [DATA_W-1:0] pc_cur,
    output logic [UA_W-1:0]   upc,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              iord,
    output logic              ir_wr,
    output logic [1:0]        alu_op,
    output logic [1:0]        alu_src1,
    output logic [2:0]        alu_src2,
    output logic [4:0]        ra_addr,
    output logic [4:0]        rb_addr,
    output logic              reg_wr,
    output logic [4:0]        wr_addr,
    output logic [1:0]        wr_src,
    output logic              hold_wr,
    output logic              pc_load,
    output logic [1:0]        pc_src,
    output logic [DATA_W-1:0] cop_rdata
);
    uinstr_t    uword;
    uaddr_t     upc_q;
    logic [5:0] opc, fn;
    logic [4:0] rs, rt, rd;
    logic       unused_shamt;

    assign opc = instr[31:26];
    assign rs  = instr[25:21];
    assign rt  = instr[20:16];
    assign rd  = instr[15:11];
    assign fn  = instr[5:0];
    assign unused_shamt = ^instr[10:6];
    assign upc = upc_q;

    mcu_useq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .seq   (uword.seq),
        .opc   (opc),
        .fn    (fn),
        .ovf   (alu_ovf),
        .upc   (upc_q)
    );

    mcu_urom u_rom (
        .addr (upc_q),
        .word (uword)
    );

    mcu_fdec u_dec (
        .u        (uword),
        .fn       (fn),
        .rs       (rs),
        .rt       (rt),
        .rd       (rd),
        .zero     (alu_zero),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .iord     (iord),
        .ir_wr    (ir_wr),
        .alu_op   (alu_op),
        .alu_src1 (alu_src1),
        .alu_src2 (alu_src2),
        .ra_addr  (ra_addr),
        .rb_addr  (rb_addr),
        .reg_wr   (reg_wr),
        .wr_addr  (wr_addr),
        .wr_src   (wr_src),
        .hold_wr  (hold_wr),
        .pc_load  (pc_load),
        .pc_src   (pc_src)
    );

    mcu_cp0 #(.DATA_W(DATA_W)) u_cp0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .trap   (uword.exc),
        .pc_cur (pc_cur),
        .sel    (rt),
        .rdata  (cop_rdata)
    );
endmodule

// File: rtl/mcu_ctrl_chk.sv
// Property checker for the control unit, attached to every instance of the
// top by the bind at the end of this file. Observes ports only.
module mcu_ctrl_chk
    import mcu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            alu_ovf,
    input logic [UA_W-1:0] upc,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            ir_wr,
    input logic            reg_wr,
    input logic [4:0]      wr_addr,
    input logic [1:0]      wr_src,
    input logic            pc_load,
    input logic [1:0]      pc_src
);
    AST_FETCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        upc == UA_FETCH |-> mem_rd && ir_wr && pc_load && pc_src == 2'd0); // R2
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        upc == UA_FETCH |=> upc == UA_DECODE); // R2
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R6
    AST_LINK_TO_R31: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && wr_src == 2'd2 |-> wr_addr == 5'd31); // R7
    AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        upc == UA_ADD1 && alu_ovf |=> upc == UA_TRAP); // R8
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        upc == UA_TRAP |-> !reg_wr && pc_load && pc_src == 2'd3); // R8
    AST_ADD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        upc == UA_ADD1 && !alu_ovf |=> upc == UA_ADD2 && reg_wr); // R9
endmodule

bind mcu_ctrl mcu_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .alu_ovf (alu_ovf),
    .upc     (upc),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .ir_wr   (ir_wr),
    .reg_wr  (reg_wr),
    .wr_addr (wr_addr),
    .wr_src  (wr_src),
    .pc_load (pc_load),
    .pc_src  (pc_src)
);

// File: tb/mcu_ctrl_tb.sv
// Directed bench: one task per instruction flow, each checking the microaddress
// trace and control word at every step.
module mcu_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        alu_zero = 1'b0;
    logic        alu_ovf = 1'b0;
    logic [31:0] pc_cur = '0;
    logic [4:0]  upc;
    logic        mem_rd, mem_wr, iord, ir_wr, reg_wr, hold_wr, pc_load;
    logic [1:0]  alu_op, alu_src1, wr_src, pc_src;
    logic [2:0]  alu_src2;
    logic [4:0]  ra_addr, rb_addr, wr_addr;
    logic [31:0] cop_rdata;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcu_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
        .pc_cur(pc_cur), .upc(upc), .mem_rd(mem_rd), .mem_wr(mem_wr), .iord(iord),
        .ir_wr(ir_wr), .alu_op(alu_op), .alu_src1(alu_src1), .alu_src2(alu_src2),
        .ra_addr(ra_addr), .rb_addr(rb_addr), .reg_wr(reg_wr), .wr_addr(wr_addr),
        .wr_src(wr_src), .hold_wr(hold_wr), .pc_load(pc_load), .pc_src(pc_src),
        .cop_rdata(cop_rdata)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [31:0] rfmt(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] ifmt(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Fetch and decode steps common to every instruction (R2, R3).
    task automatic fetch_decode(logic [31:0] ins);
        instr = ins;
        chk("R2", "fetch upc", upc, 0);
        chk("R2", "fetch mem/ir/iord", {mem_rd, ir_wr, iord}, 3'b110);
        chk("R2", "fetch alu", {alu_op, alu_src1, alu_src2}, {2'd0, 2'd0, 3'd1});
        chk("R2", "fetch pc", {pc_load, pc_src}, {1'b1, 2'd0});
        tick();
        chk("R3", "decode upc", upc, 1);
        chk("R3", "decode alu", {alu_op, alu_src1, alu_src2}, {2'd0, 2'd0, 3'd3});
        chk("R3", "decode quiet", {pc_load, reg_wr}, 2'b00);
        tick();
    endtask

    task automatic t_rfmt(logic [5:0] fn, logic [1:0] exp_op, logic ovf);
        fetch_decode(rfmt(5'd4, 5'd7, 5'd9, fn));
        chk("R3", "rfmt dispatch", upc, 2);
        chk("R4", "rfmt op", alu_op, exp_op);
        chk("R4", "rfmt srcs", {ra_addr, rb_addr}, {5'd4, 5'd7});
        alu_ovf = ovf;
        tick();
        alu_ovf = 1'b0;
        chk("R4", "rfmt writeback upc (no trap)", upc, 3);
        chk("R4", "rfmt write rd", {reg_wr, wr_addr, wr_src}, {1'b1, 5'd9, 2'd0});
        tick();
        chk("R4", "rfmt return", upc, 0);
    endtask

    task automatic t_beq(logic z);
        fetch_decode(ifmt(6'h04, 5'd3, 5'd5, 16'h0010));
        chk("R3", "beq dispatch", upc, 4);
        alu_zero = z;
        #1;
        chk("R5", "beq op", alu_op, 1);
        chk("R5", "beq pc", {pc_load, pc_src}, {z, 2'd1});
        tick();
        alu_zero = 1'b0;
        chk("R5", "beq return", upc, 0);
    endtask

    task automatic t_ori();
        fetch_decode(ifmt(6'h0D, 5'd6, 5'd12, 16'h00FF));
        chk("R3", "ori dispatch", upc, 5);
        chk("R6", "ori alu", {alu_op, alu_src2}, {2'd2, 3'd4});
        tick();
        chk("R6", "ori write rt", {upc, reg_wr, wr_addr, wr_src}, {5'd6, 1'b1, 5'd12, 2'd0});
        tick();
        chk("R6", "ori return", upc, 0);
    endtask

    task automatic t_lw();
        fetch_decode(ifmt(6'h23, 5'd8, 5'd13, 16'hFFFC));
        chk("R3", "lw dispatch", upc, 7);
        chk("R6", "lw addr alu", {alu_op, alu_src1, alu_src2}, {2'd0, 2'd1, 3'd2});
        tick();
        chk("R6", "lw read", {upc, mem_rd, iord, ir_wr}, {5'd8, 1'b1, 1'b1, 1'b0});
        tick();
        chk("R6", "lw write rt", {upc, reg_wr, wr_addr, wr_src}, {5'd9, 1'b1, 5'd13, 2'd1});
        tick();
        chk("R6", "lw return", upc, 0);
    endtask

    task automatic t_sw();
        fetch_decode(ifmt(6'h2B, 5'd8, 5'd14, 16'h0008));
        chk("R3", "sw dispatch", upc, 10);
        tick();
        chk("R6", "sw write mem", {upc, mem_wr, mem_rd, iord, reg_wr}, {5'd11, 1'b1, 1'b0, 1'b1, 1'b0});
        chk("R6", "sw data reg", rb_addr, 14);
        tick();
        chk("R6", "sw return", upc, 0);
    endtask

    task automatic t_jal();
        fetch_decode({6'h03, 26'h0000040});
        chk("R7", "jal dispatch", upc, 12);
        chk("R7", "jal link", {reg_wr, wr_addr, wr_src}, {1'b1, 5'd31, 2'd2});
        chk("R7", "jal pc", {pc_load, pc_src}, {1'b1, 2'd2});
        tick();
        chk("R7", "jal return", upc, 0);
    endtask

    task automatic t_add(logic ovf);
        pc_cur = 32'h0000_1008;
        fetch_decode(rfmt(5'd2, 5'd3, 5'd8, 6'h20));
        chk("R3", "add dispatch", upc, 13);
        alu_ovf = ovf;
        tick();
        alu_ovf = 1'b0;
        if (ovf) begin
            chk("R8", "trap upc", upc, 15);
            chk("R8", "trap no write", reg_wr, 0);
            chk("R8", "trap pc", {pc_load, pc_src}, {1'b1, 2'd3});
        end else begin
            chk("R9", "add commit upc", upc, 14);
            chk("R9", "add write rd", {reg_wr, wr_addr, wr_src}, {1'b1, 5'd8, 2'd0});
        end
        tick();
        chk(ovf ? "R8" : "R9", "add return", upc, 0);
    endtask

    task automatic t_mfc0(logic [4:0] sel, logic [4:0] rd, logic [31:0] exp, string req);
        fetch_decode({6'h10, 5'd0, sel, rd, 11'd0});
        chk("R3", "mfc0 dispatch", upc, 16);
        chk("R10", "mfc0 write rd", {reg_wr, wr_addr, wr_src}, {1'b1, rd, 2'd3});
        chk(req, "mfc0 value", cop_rdata, exp);
        tick();
        chk("R10", "mfc0 return", upc, 0);
    endtask

    task automatic t_cmul();
        fetch_decode(rfmt(5'd2, 5'd6, 5'd10, 6'h3A));
        chk("R11", "cm1", {upc, alu_op, alu_src1, alu_src2, ra_addr, rb_addr, hold_wr, reg_wr},
            {5'd17, 2'd3, 2'd1, 3'd0, 5'd2, 5'd6, 1'b0, 1'b0});
        tick();
        chk("R11", "cm2", {upc, alu_op, ra_addr, rb_addr, hold_wr, reg_wr},
            {5'd18, 2'd3, 5'd3, 5'd7, 1'b1, 1'b0});
        tick();
        chk("R11", "cm3", {upc, alu_op, alu_src1, alu_src2, reg_wr},
            {5'd19, 2'd1, 2'd2, 3'd5, 1'b0});
        tick();
        chk("R11", "cm4", {upc, alu_op, ra_addr, rb_addr, reg_wr, wr_addr, wr_src},
            {5'd20, 2'd3, 5'd2, 5'd7, 1'b1, 5'd10, 2'd0});
        tick();
        chk("R11", "cm5", {upc, alu_op, ra_addr, rb_addr, hold_wr, reg_wr},
            {5'd21, 2'd3, 5'd3, 5'd6, 1'b1, 1'b0});
        tick();
        chk("R11", "cm6", {upc, alu_op, alu_src1, alu_src2, reg_wr},
            {5'd22, 2'd0, 2'd2, 3'd5, 1'b0});
        tick();
        chk("R11", "cm7", {upc, reg_wr, wr_addr, wr_src}, {5'd23, 1'b1, 5'd11, 2'd0});
        tick();
        chk("R11", "cm return", upc, 0);
    endtask

    task automatic t_unknown(logic [31:0] ins);
        fetch_decode(ins);
        chk("R12", "unknown returns to fetch", upc, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        instr = {6'h10, 5'd0, 5'd13, 5'd0, 11'd0};
        #1;
        chk("R1", "reset upc", upc, 0);
        chk("R1", "reset cause", cop_rdata, 0);
        instr = {6'h10, 5'd0, 5'd14, 5'd0, 11'd0};
        #1;
        chk("R1", "reset epc", cop_rdata, 0);
        t_rfmt(6'h21, 2'd0, 1'b1);
        t_rfmt(6'h23, 2'd1, 1'b0);
        t_beq(1'b1);
        t_beq(1'b0);
        t_ori();
        t_lw();
        t_sw();
        t_jal();
        t_add(1'b0);
        t_add(1'b1);
        t_mfc0(5'd13, 5'd20, 32'd12, "R8");
        t_mfc0(5'd14, 5'd21, 32'h0000_1004, "R8");
        t_mfc0(5'd5, 5'd22, 32'd0, "R10");
        t_cmul();
        t_unknown(ifmt(6'h3F, 5'd1, 5'd2, 16'h0));
        t_unknown(rfmt(5'd1, 5'd2, 5'd3, 6'h2A));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule